// File: doc/BRIEF.md
# Instruction Decode Pipeline Stage

This block is the second stage of a five-stage, in-order 32-bit RISC-V integer pipeline. It sits between fetch and execute. Each cycle it can accept one fetched packet: a 32-bit instruction word, the PC of that instruction, and the branch predictor's taken bit. It holds the packet in a single stage register and presents it to execute, together with the fields decoded from it. Those fields are the opcode, funct3, funct7, the destination and source register numbers, a one-hot instruction-format flag vector, a 4-bit ALU operation code, and the raw immediate fields of every format.

The register file takes one cycle to read. The stage therefore sends both source register numbers to it straight from the incoming fetch packet, with no register in between. The read data then reach execute in the same cycle as the registered payload.

Both the fetch-side and the execute-side interfaces use valid/ready. The stage makes no stall of its own, so `in_ready` simply follows `out_ready`. While `out_ready` is low, the stage register is frozen, `in_ready` is low so fetch holds its packet, and `rf_stall` is high so the register file holds its read data. A branch flush from execute hides the outgoing packet combinationally in the cycle it is raised, and empties the stage register at the next edge. A flush wins over a stall.

Top module: `rv_decode_stage`

## Requirements
- R1: The decoded fields are taken from the registered instruction at these positions: opcode = bits 6:0, rd = bits 11:7, funct3 = bits 14:12, rs1 = bits 19:15, rs2 = bits 24:20, funct7 = bits 31:25.
- R2: `out_kind` has bit 0 = R format (opcode 0x33), bit 1 = I format (0x03, 0x13, 0x67), bit 2 = S format (0x23), bit 3 = B format (0x63), bit 4 = U format (0x17, 0x37), bit 5 = J format (0x6F). Any other opcode gives all zeros, and at most one bit is ever set.
- R3: `out_alu_code` is {funct3, instr[30]} for opcode 0x33 and for opcode 0x13 with funct3 = 001 or 101. It is {funct3, 0} for the other I-format opcodes and 4'b0000 for every other opcode.
- R4: The immediates are: I = instr[31:20]; S = {instr[31:25], instr[11:7]}; B = {instr[31], instr[7], instr[30:25], instr[11:8]}; U = instr[31:12]; J = {instr[31], instr[19:12], instr[20], instr[30:21]}.
- R5: A packet accepted at a clock edge (`in_valid` and `in_ready` high, `flush` low) appears on `out_instr`, `out_pc` and `out_taken` with `out_valid` high just after that edge. The taken bit is carried forward unchanged.
- R6: `rf_rs1_addr` and `rf_rs2_addr` equal bits 19:15 and 24:20 of `in_instr` in the same cycle. Once the packet is accepted, they match `out_rs1` and `out_rs2` one cycle later.
- R7: While `flush` is high, `out_valid` is low in that same cycle. After an edge at which `flush` was high, `out_valid` is low even if a packet was offered or the stage was stalled.
- R8: While `out_ready` is low and `flush` is low, the stage register holds its valid bit, instruction, PC and taken bit. `in_ready` equals `out_ready`, and `rf_stall` is the inverse of `out_ready`.
- R9: `out_bubble` is always the inverse of `out_valid`. An edge with `out_ready` high and `in_valid` low leaves the stage empty.
- R10: After reset, `out_valid` is low and `out_bubble` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Fetch packet valid |
| in_ready | output | 1 | Stage can take a packet |
| in_instr | input | 32 | Fetched instruction word |
| in_pc | input | PC_W | PC of the fetched instruction |
| in_taken | input | 1 | Predicted-taken bit from fetch |
| rf_rs1_addr | output | 5 | First source register number to the register file |
| rf_rs2_addr | output | 5 | Second source register number to the register file |
| rf_stall | output | 1 | Hold request to the register file |
| flush | input | 1 | Branch flush from execute |
| out_valid | output | 1 | Payload to execute is valid |
| out_ready | input | 1 | Execute can take the payload |
| out_bubble | output | 1 | Inverse of out_valid |
| out_instr | output | 32 | Registered instruction word |
| out_pc | output | PC_W | Registered PC |
| out_taken | output | 1 | Registered predicted-taken bit |
| out_opcode | output | 7 | Opcode field |
| out_rd | output | 5 | Destination register number |
| out_funct3 | output | 3 | funct3 field |
| out_rs1 | output | 5 | First source register number |
| out_rs2 | output | 5 | Second source register number |
| out_funct7 | output | 7 | funct7 field |
| out_kind | output | 6 | One-hot format flags (R2 bit order) |
| out_alu_code | output | 4 | ALU operation code |
| out_imm_i | output | 12 | I-format immediate |
| out_imm_s | output | 12 | S-format immediate |
| out_imm_b | output | 12 | B-format immediate |
| out_imm_u | output | 20 | U-format immediate |
| out_imm_j | output | 20 | J-format immediate |

## Verification
A stall and a branch flush can arrive in the same cycle. At that moment the stage register holds a valid packet and fetch is offering another. The bench provokes this by holding `out_ready` low on a loaded stage and raising `flush` while a new packet waits on the input. It judges the result on three points: `out_valid` must fall in that very cycle, the held packet must not come back, and the waiting packet must not appear once the stall is released. Flush against a free-running stage and stall on its own are covered separately, so that each rule is seen apart from the other.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

  localparam int unsigned ILEN    = 32;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned OPC_W   = 7;
  localparam int unsigned F3_W    = 3;
  localparam int unsigned F7_W    = 7;
  localparam int unsigned ALU_W   = 4;
  localparam int unsigned IMM12_W = 12;
  localparam int unsigned IMM20_W = 20;
  localparam int unsigned KIND_W  = 6;

  localparam logic [OPC_W-1:0] OPC_REG    = 7'h33;
  localparam logic [OPC_W-1:0] OPC_IMM    = 7'h13;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'h03;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'h67;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'h23;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'h63;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'h37;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'h17;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'h6F;

  localparam logic [F3_W-1:0] F3_SLL = 3'b001;
  localparam logic [F3_W-1:0] F3_SRX = 3'b101;

  // first member lands in the top bit, so fmt_r is bit 0
  typedef struct packed {
    logic fmt_j;
    logic fmt_u;
    logic fmt_b;
    logic fmt_s;
    logic fmt_i;
    logic fmt_r;
  } kind_t;

  typedef struct packed {
    logic [F7_W-1:0]   funct7;
    logic [REG_AW-1:0] rs2;
    logic [REG_AW-1:0] rs1;
    logic [F3_W-1:0]   funct3;
    logic [REG_AW-1:0] rd;
    logic [OPC_W-1:0]  opcode;
  } fields_t;

  typedef struct packed {
    logic [IMM20_W-1:0] imm_j;
    logic [IMM20_W-1:0] imm_u;
    logic [IMM12_W-1:0] imm_b;
    logic [IMM12_W-1:0] imm_s;
    logic [IMM12_W-1:0] imm_i;
  } imms_t;

endpackage

// File: rtl/rvdec_stage_reg.sv
module rvdec_stage_reg #(
  parameter int unsigned DATA_W = 65
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              advance,
  input  logic              d_valid,
  input  logic [DATA_W-1:0] d_data,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data
);

  logic load_data;
  assign load_data = advance & d_valid & ~flush;

  // valid bit: flush first, then stall, then take input (bubble if none)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
    end else if (flush) begin
      q_valid <= 1'b0;
    end else if (advance) begin
      q_valid <= d_valid;
    end
  end

  // payload carries no reset: its value is meaningless while q_valid is low
  always_ff @(posedge clk) begin
    if (load_data) begin
      q_data <= d_data;
    end
  end

endmodule

// File: rtl/rvdec_field_split.sv
module rvdec_field_split
  import rvdec_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output fields_t         fld,
  output kind_t           kind
);

  always_comb begin
    fld.opcode = instr[6:0];
    fld.rd     = instr[11:7];
    fld.funct3 = instr[14:12];
    fld.rs1    = instr[19:15];
    fld.rs2    = instr[24:20];
    fld.funct7 = instr[31:25];
  end

  always_comb begin
    kind = '0;
    case (instr[6:0])
      OPC_REG:                      kind.fmt_r = 1'b1;
      OPC_IMM, OPC_LOAD, OPC_JALR:  kind.fmt_i = 1'b1;
      OPC_STORE:                    kind.fmt_s = 1'b1;
      OPC_BRANCH:                   kind.fmt_b = 1'b1;
      OPC_LUI, OPC_AUIPC:           kind.fmt_u = 1'b1;
      OPC_JAL:                      kind.fmt_j = 1'b1;
      default:                      kind = '0;
    endcase
  end

endmodule

// File: rtl/rvdec_alu_imm.sv
module rvdec_alu_imm
  import rvdec_pkg::*;
(
  input  logic [ILEN-1:0]  instr,
  input  logic             is_r,
  input  logic             is_i,
  output logic [ALU_W-1:0] alu_code,
  output imms_t            imm
);

  logic [F3_W-1:0] f3;
  logic            shift_imm;
  logic            alt_bit;

  assign f3        = instr[14:12];
  assign alt_bit   = instr[30];
  assign shift_imm = (instr[6:0] == OPC_IMM) & ((f3 == F3_SLL) | (f3 == F3_SRX));

  // U format and all non-ALU formats fall through to zero
  always_comb begin
    if (is_r || shift_imm) begin
      alu_code = {f3, alt_bit};
    end else if (is_i) begin
      alu_code = {f3, 1'b0};
    end else begin
      alu_code = '0;
    end
  end

  always_comb begin
    imm.imm_i = instr[31:20];
    imm.imm_s = {instr[31:25], instr[11:7]};
    imm.imm_b = {instr[31], instr[7], instr[30:25], instr[11:8]};
    imm.imm_u = instr[31:12];
    imm.imm_j = {instr[31], instr[19:12], instr[20], instr[30:21]};
  end

endmodule

// File: rtl/rv_decode_stage.sv
module rv_decode_stage
  import rvdec_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [ILEN-1:0]     in_instr,
  input  logic [PC_W-1:0]     in_pc,
  input  logic                in_taken,
  output logic [REG_AW-1:0]   rf_rs1_addr,
  output logic [REG_AW-1:0]   rf_rs2_addr,
  output logic                rf_stall,
  input  logic                flush,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_bubble,
  output logic [ILEN-1:0]     out_instr,
  output logic [PC_W-1:0]     out_pc,
  output logic                out_taken,
  output logic [OPC_W-1:0]    out_opcode,
  output logic [REG_AW-1:0]   out_rd,
  output logic [F3_W-1:0]     out_funct3,
  output logic [REG_AW-1:0]   out_rs1,
  output logic [REG_AW-1:0]   out_rs2,
  output logic [F7_W-1:0]     out_funct7,
  output logic [KIND_W-1:0]   out_kind,
  output logic [ALU_W-1:0]    out_alu_code,
  output logic [IMM12_W-1:0]  out_imm_i,
  output logic [IMM12_W-1:0]  out_imm_s,
  output logic [IMM12_W-1:0]  out_imm_b,
  output logic [IMM20_W-1:0]  out_imm_u,
  output logic [IMM20_W-1:0]  out_imm_j
);

  localparam int unsigned PKT_W = 1 + PC_W + ILEN;

  logic [PKT_W-1:0] pkt_d;
  logic [PKT_W-1:0] pkt_q;
  logic             vld_q;
  fields_t          fld;
  kind_t            kind;
  imms_t            imm;

  // back-pressure passes straight through; no local stall source
  assign in_ready = out_ready;
  assign rf_stall = ~out_ready;

  // register-file addresses bypass the stage register to meet a 1-cycle read
  assign rf_rs1_addr = in_instr[19:15];
  assign rf_rs2_addr = in_instr[24:20];

  assign pkt_d = {in_taken, in_pc, in_instr};

  rvdec_stage_reg #(
    .DATA_W (PKT_W)
  ) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .advance (out_ready),
    .d_valid (in_valid),
    .d_data  (pkt_d),
    .q_valid (vld_q),
    .q_data  (pkt_q)
  );

  assign out_instr = pkt_q[ILEN-1:0];
  assign out_pc    = pkt_q[ILEN +: PC_W];
  assign out_taken = pkt_q[PKT_W-1];

  // flush hides the payload in the cycle it is raised
  assign out_valid  = vld_q & ~flush;
  assign out_bubble = ~out_valid;

  rvdec_field_split u_split (
    .instr (out_instr),
    .fld   (fld),
    .kind  (kind)
  );

  rvdec_alu_imm u_aluimm (
    .instr    (out_instr),
    .is_r     (kind.fmt_r),
    .is_i     (kind.fmt_i),
    .alu_code (out_alu_code),
    .imm      (imm)
  );

  assign out_opcode = fld.opcode;
  assign out_rd     = fld.rd;
  assign out_funct3 = fld.funct3;
  assign out_rs1    = fld.rs1;
  assign out_rs2    = fld.rs2;
  assign out_funct7 = fld.funct7;
  assign out_kind   = kind;
  assign out_imm_i  = imm.imm_i;
  assign out_imm_s  = imm.imm_s;
  assign out_imm_b  = imm.imm_b;
  assign out_imm_u  = imm.imm_u;
  assign out_imm_j  = imm.imm_j;

endmodule

// File: rtl/rv_decode_stage_chk.sv
module rv_decode_stage_chk
  import rvdec_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ILEN-1:0]   in_instr,
  input logic [PC_W-1:0]   in_pc,
  input logic              in_taken,
  input logic [REG_AW-1:0] rf_rs1_addr,
  input logic [REG_AW-1:0] rf_rs2_addr,
  input logic              rf_stall,
  input logic              flush,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_bubble,
  input logic [ILEN-1:0]   out_instr,
  input logic [PC_W-1:0]   out_pc,
  input logic              out_taken,
  input logic [REG_AW-1:0] out_rs1,
  input logic [REG_AW-1:0] out_rs2,
  input logic [KIND_W-1:0] out_kind
);

  assert_kind_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_kind));

  assert_load_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !flush) |=>
      (out_instr == $past(in_instr) && out_pc == $past(in_pc) && out_taken == $past(in_taken)));

  assert_rf_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !flush) |=>
      (out_rs1 == $past(rf_rs1_addr) && out_rs2 == $past(rf_rs2_addr)));

  assert_flush_same_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !out_valid);

  assert_flush_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=>
      ($stable(out_instr) && $stable(out_pc) && $stable(out_taken) && (out_valid || flush)));

  assert_stall_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready == out_ready) && (rf_stall == !out_ready));

  assert_bubble_inv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_bubble == !out_valid);

  assert_empty_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);

endmodule

bind rv_decode_stage rv_decode_stage_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/rv_decode_stage_tb_top.sv
`timescale 1ns/1ps
module rv_decode_stage_tb_top;

  localparam int PC_W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [31:0] in_pc = '0;
  logic        in_taken = 1'b0;
  logic [4:0]  rf_rs1_addr, rf_rs2_addr;
  logic        rf_stall;
  logic        flush = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_bubble;
  logic [31:0] out_instr, out_pc;
  logic        out_taken;
  logic [6:0]  out_opcode, out_funct7;
  logic [4:0]  out_rd, out_rs1, out_rs2;
  logic [2:0]  out_funct3;
  logic [5:0]  out_kind;
  logic [3:0]  out_alu_code;
  logic [11:0] out_imm_i, out_imm_s, out_imm_b;
  logic [19:0] out_imm_u, out_imm_j;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rv_decode_stage #(.PC_W(PC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_pc(in_pc), .in_taken(in_taken),
    .rf_rs1_addr(rf_rs1_addr), .rf_rs2_addr(rf_rs2_addr), .rf_stall(rf_stall),
    .flush(flush), .out_valid(out_valid), .out_ready(out_ready),
    .out_bubble(out_bubble), .out_instr(out_instr), .out_pc(out_pc),
    .out_taken(out_taken), .out_opcode(out_opcode), .out_rd(out_rd),
    .out_funct3(out_funct3), .out_rs1(out_rs1), .out_rs2(out_rs2),
    .out_funct7(out_funct7), .out_kind(out_kind), .out_alu_code(out_alu_code),
    .out_imm_i(out_imm_i), .out_imm_s(out_imm_s), .out_imm_b(out_imm_b),
    .out_imm_u(out_imm_u), .out_imm_j(out_imm_j)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_kind(input logic [31:0] w);
    logic [6:0] op = w[6:0];
    if (op == 7'h33) return 6'b000001;
    if (op == 7'h03 || op == 7'h13 || op == 7'h67) return 6'b000010;
    if (op == 7'h23) return 6'b000100;
    if (op == 7'h63) return 6'b001000;
    if (op == 7'h37 || op == 7'h17) return 6'b010000;
    if (op == 7'h6F) return 6'b100000;
    return 6'b000000;
  endfunction

  function automatic logic [3:0] ref_alu(input logic [31:0] w);
    logic [2:0] f = w[14:12];
    case (w[6:0])
      7'h33: return {f, w[30]};
      7'h13: return (f == 3'd1 || f == 3'd5) ? {f, w[30]} : {f, 1'b0};
      7'h03, 7'h67: return {f, 1'b0};
      default: return 4'h0;
    endcase
  endfunction

  task automatic drive(input logic v, input logic [31:0] w, input logic [31:0] pc, input logic t);
    @(negedge clk);
    in_valid = v; in_instr = w; in_pc = pc; in_taken = t;
  endtask

  task automatic check_decode(input logic [31:0] w);
    chk("R1 opcode", 32'(out_opcode), 32'(w[6:0]));
    chk("R1 rd",     32'(out_rd),     32'(w[11:7]));
    chk("R1 funct3", 32'(out_funct3), 32'(w[14:12]));
    chk("R1 rs1",    32'(out_rs1),    32'(w[19:15]));
    chk("R1 rs2",    32'(out_rs2),    32'(w[24:20]));
    chk("R1 funct7", 32'(out_funct7), 32'(w[31:25]));
    chk("R2 kind",   32'(out_kind),   32'(ref_kind(w)));
    chk("R3 alu",    32'(out_alu_code), 32'(ref_alu(w)));
    chk("R4 imm_i",  32'(out_imm_i), 32'(w[31:20]));
    chk("R4 imm_s",  32'(out_imm_s), 32'({w[31:25], w[11:7]}));
    chk("R4 imm_b",  32'(out_imm_b), 32'({w[31], w[7], w[30:25], w[11:8]}));
    chk("R4 imm_u",  32'(out_imm_u), 32'(w[31:12]));
    chk("R4 imm_j",  32'(out_imm_j), 32'({w[31], w[19:12], w[20], w[30:21]}));
  endtask

  // push one packet and check the full payload after the edge
  task automatic push_and_check(input logic [31:0] w, input logic [31:0] pc, input logic t);
    logic [4:0] a1, a2;
    drive(1'b1, w, pc, t);
    #1;
    a1 = rf_rs1_addr; a2 = rf_rs2_addr;
    chk("R6 rf_rs1 comb", 32'(a1), 32'(w[19:15]));
    chk("R6 rf_rs2 comb", 32'(a2), 32'(w[24:20]));
    @(posedge clk); #1;
    chk("R5 valid", 32'(out_valid), 32'd1);
    chk("R5 instr", out_instr, w);
    chk("R5 pc",    out_pc, pc);
    chk("R5 taken", 32'(out_taken), 32'(t));
    chk("R6 rs1 after", 32'(out_rs1), 32'(a1));
    chk("R6 rs2 after", 32'(out_rs2), 32'(a2));
    check_decode(w);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 valid in reset", 32'(out_valid), 32'd0);
    chk("R10 bubble in reset", 32'(out_bubble), 32'd1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 valid after reset", 32'(out_valid), 32'd0);
  endtask

  task automatic t_directed;
    push_and_check(32'h00C58533, 32'h100, 1'b0);
    push_and_check(32'h40B50533, 32'h104, 1'b1);
    push_and_check(32'h40355513, 32'h108, 1'b0);
    push_and_check(32'h00351513, 32'h10C, 1'b0);
    push_and_check(32'hFFF50513, 32'h110, 1'b1);
    push_and_check(32'h00452503, 32'h114, 1'b0);
    push_and_check(32'h000500E7, 32'h118, 1'b0);
    push_and_check(32'hFEA5AE23, 32'h11C, 1'b0);
    push_and_check(32'hFE0508E3, 32'h120, 1'b1);
    push_and_check(32'hABCDE537, 32'h124, 1'b0);
    push_and_check(32'h12345517, 32'h128, 1'b0);
    push_and_check(32'h8000006F, 32'h12C, 1'b1);
    push_and_check(32'hFFFFFFFF, 32'h130, 1'b0);
  endtask

  task automatic t_random;
    logic [6:0] ops [10] = '{7'h33, 7'h13, 7'h03, 7'h67, 7'h23, 7'h63, 7'h37, 7'h17, 7'h6F, 7'h0B};
    for (int n = 0; n < 200; n++) begin
      logic [31:0] w;
      w = $urandom;
      w[6:0] = ops[$urandom % 10];
      push_and_check(w, $urandom, 1'($urandom));
    end
  endtask

  task automatic t_stall;
    logic [31:0] a = 32'h00A28293;
    logic [31:0] b = 32'h0062A023;
    push_and_check(a, 32'h200, 1'b1);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_instr = b; in_pc = 32'h204; in_taken = 1'b0;
    #1;
    chk("R8 in_ready low", 32'(in_ready), 32'd0);
    chk("R8 rf_stall high", 32'(rf_stall), 32'd1);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R8 held valid", 32'(out_valid), 32'd1);
      chk("R8 held instr", out_instr, a);
      chk("R8 held pc", out_pc, 32'h200);
      chk("R8 held taken", 32'(out_taken), 32'd1);
    end
    @(negedge clk); out_ready = 1'b1;
    #1;
    chk("R8 in_ready back", 32'(in_ready), 32'd1);
    chk("R8 rf_stall low", 32'(rf_stall), 32'd0);
    @(posedge clk); #1;
    chk("R8 release instr", out_instr, b);
    chk("R8 release pc", out_pc, 32'h204);
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R9 bubble fill valid", 32'(out_valid), 32'd0);
    chk("R9 bubble flag", 32'(out_bubble), 32'd1);
  endtask

  task automatic t_flush;
    push_and_check(32'h00000013, 32'h300, 1'b0);
    @(negedge clk);
    in_valid = 1'b1; in_instr = 32'h00100093; in_pc = 32'h304;
    flush = 1'b1;
    #1;
    chk("R7 same-cycle kill", 32'(out_valid), 32'd0);
    chk("R9 bubble on flush", 32'(out_bubble), 32'd1);
    @(negedge clk);
    flush = 1'b0; in_valid = 1'b0;
    #1;
    chk("R7 cleared after edge", 32'(out_valid), 32'd0);
    @(posedge clk); #1;
    chk("R7 stays empty", 32'(out_valid), 32'd0);
  endtask

  task automatic t_flush_stall;
    push_and_check(32'h00200113, 32'h400, 1'b1);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_instr = 32'h00300193; in_pc = 32'h404;
    @(posedge clk); #1;
    chk("R8 held before flush", out_instr, 32'h00200113);
    @(negedge clk); flush = 1'b1;
    #1;
    chk("R7 kill under stall", 32'(out_valid), 32'd0);
    @(negedge clk);
    flush = 1'b0;
    #1;
    chk("R7 flush beats stall", 32'(out_valid), 32'd0);
    out_ready = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R7 no replay", 32'(out_valid), 32'd0);
  endtask

  initial begin
    t_reset();
    t_directed();
    t_random();
    t_stall();
    t_flush();
    t_flush_stall();
    @(negedge clk); in_valid = 1'b0;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule